// File: doc/BRIEF.md
# Message-to-Bus Read/Write Transactor

This block turns host request messages into activity on a simple memory-mapped bus. Requests arrive one at a time on a fixed-width input message port with a valid/ready handshake. Each one is a bus read, a bus write, or a command to drive the design's side-band reset. The block turns each request into cycle-exact bus phases. It then collects the design's answer and returns it as one reply message on a fixed-width output port. Rising edges of the design's interrupt line are also sent to the host, as messages of their own.

While it is unpacking a request or packing a reply, the block asks the clock infrastructure to stop the controlled design clock. It waits for the acknowledge before going on. Only one request is in flight at any time.

The controller is a single state machine with seven states:
- `ST_IDLE` goes to `ST_IRQ_SEND` when an interrupt is pending. Otherwise it goes to `ST_FREEZE_IN` when a request is accepted.
- `ST_FREEZE_IN` waits for the stop acknowledge. It then goes to `ST_ADDR` for a read or write, or to `ST_FREEZE_OUT` for a reset command.
- `ST_ADDR` always goes to `ST_DATA`.
- `ST_DATA` goes to `ST_FREEZE_OUT` once the bus ready input is high.
- `ST_FREEZE_OUT` goes to `ST_REPLY` once the stop acknowledge is high.
- `ST_REPLY` and `ST_IRQ_SEND` each return to `ST_IDLE` when the host takes the message.

Top module: `msg_bus_xactor`

## Requirements
- R1: After reset the block shows `req_ready`=1, `rsp_valid`=0, `bus_sel`=0, `bus_enable`=0 and `clk_stop_req`=0. It also holds the design in reset (`dut_rst_n`=0).
- R2: A request message is {op[1:0] in the top bits, address, write data in the low bits}. The op codes are 0=read, 1=write, 2=assert design reset and 3=release design reset. A request is taken on a cycle where `req_valid` and `req_ready` are both high.
- R3: After a request is taken, `clk_stop_req` rises and stays high until `clk_stop_ack` is seen. No bus phase is driven while `clk_stop_req` is high.
- R4: A read or write drives exactly one address-phase cycle (`bus_sel`=1, `bus_enable`=0). In that cycle `bus_addr` equals the request address, `bus_write` is 1 only for a write, and `bus_wdata` carries the write data.
- R5: The data phase (`bus_sel`=1, `bus_enable`=1) holds its address steady. It lasts until the cycle in which `bus_ready` is high, so it covers wait+1 cycles.
- R6: A read replies with {type=1, the `bus_rdata` value sampled in the cycle where `bus_ready` was high}.
- R7: A write replies with {type=0, data=0}.
- R8: Op 2 drives `dut_rst_n` low and op 3 drives it high. Neither causes any bus phase, and each replies with {type=0, data=0}.
- R9: After the bus phases, `clk_stop_req` is raised again and the reply appears only after the acknowledge. With an acknowledge that comes d cycles late, a read or write holds `clk_stop_req` for 2(d+1) cycles and a reset command for d+2 cycles.
- R10: A reply holds `rsp_msg` steady while `rsp_valid`=1 and `rsp_ready`=0. No request is taken while a reply is waiting.
- R11: Each rising edge of `dut_irq` produces one reply {type=2, data=0}. Edges not yet reported are counted, and the count stops at 2^IRQ_CNT_W-1.
- R12: In `ST_IDLE`, a pending interrupt message is sent before a waiting request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running transactor clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request message present |
| req_ready | output | 1 | Block can take a request |
| req_msg | input | 2+ADDR_W+DATA_W | Request {op, address, write data} |
| rsp_valid | output | 1 | Reply message present |
| rsp_ready | input | 1 | Host takes the reply |
| rsp_msg | output | 2+DATA_W | Reply {type, data} |
| clk_stop_req | output | 1 | Ask for the controlled clock to stop |
| clk_stop_ack | input | 1 | Controlled clock is stopped |
| bus_sel | output | 1 | Bus transfer selected (both phases) |
| bus_enable | output | 1 | Data phase active |
| bus_write | output | 1 | Transfer is a write |
| bus_addr | output | ADDR_W | Transfer address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data from the design |
| bus_ready | input | 1 | Design completes the data phase |
| dut_rst_n | output | 1 | Side-band active-low reset to the design |
| dut_irq | input | 1 | Interrupt request from the design |

## Verification
The bench builds the block with 8-bit address and data and a 2-bit interrupt counter. This keeps the messages short. It also lets the bench sweep every word of a 16-word bus model under every pairing of 0 to 3 bus wait cycles and 0 to 2 acknowledge delays. Because the counter is only 2 bits wide, five interrupt pulses during one long transfer are enough to reach the saturation limit of three pending messages. Expected read data, phase lengths and stop-request lengths are computed from the sweep indices.

// File: rtl/xact_pkg.sv
package xact_pkg;

    typedef enum logic [1:0] {
        OP_READ    = 2'd0,
        OP_WRITE   = 2'd1,
        OP_RST_ON  = 2'd2,
        OP_RST_OFF = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RT_WACK  = 2'd0,
        RT_RDATA = 2'd1,
        RT_IRQ   = 2'd2
    } rsp_type_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FREEZE_IN,
        ST_ADDR,
        ST_DATA,
        ST_FREEZE_OUT,
        ST_REPLY,
        ST_IRQ_SEND
    } xact_state_e;

endpackage

// File: rtl/xact_req_latch.sv
module xact_req_latch
    import xact_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int REQ_W = 2 + ADDR_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [REQ_W-1:0]  req_msg,
    output op_e               op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);

    // Field split of an incoming request: op on top, data at the bottom.
    logic [1:0]        op_f;
    logic [ADDR_W-1:0] addr_f;
    logic [DATA_W-1:0] wdata_f;

    always_comb begin
        op_f    = req_msg[REQ_W-1 -: 2];
        addr_f  = req_msg[DATA_W +: ADDR_W];
        wdata_f = req_msg[DATA_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_READ;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (load) begin
            op_q    <= op_e'(op_f);
            addr_q  <= addr_f;
            wdata_q <= wdata_f;
        end
    end

endmodule

// File: rtl/xact_irq_tracker.sv
module xact_irq_tracker #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_in,
    input  logic take,
    output logic pending
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             irq_prev_q;
    logic             edge_seen;
    logic [CNT_W-1:0] cnt_q;

    assign edge_seen = irq_in && !irq_prev_q;
    assign pending   = (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_prev_q <= 1'b0;
            cnt_q      <= '0;
        end else begin
            irq_prev_q <= irq_in;
            unique case ({edge_seen, take})
                2'b10:   if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    AST_IRQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_in) |=> pending); // R11

    AST_TAKE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> pending); // R12

endmodule

// File: rtl/xact_rsp_builder.sv
module xact_rsp_builder
    import xact_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int RSP_W = 2 + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_rdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              load_rsp,
    input  logic              is_read,
    input  logic              load_irq,
    input  logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [RSP_W-1:0]  rsp_msg
);

    rsp_type_e         type_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            type_q <= RT_WACK;
            data_q <= '0;
        end else if (load_irq) begin
            type_q <= RT_IRQ;
            data_q <= '0;
        end else if (load_rsp) begin
            type_q <= is_read ? RT_RDATA : RT_WACK;
            if (!is_read) data_q <= '0;
        end else if (cap_rdata) begin
            data_q <= bus_rdata;
        end
    end

    assign rsp_msg = {type_q, data_q};

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_msg))); // R10

endmodule

// File: rtl/xact_ctrl_fsm.sv
module xact_ctrl_fsm
    import xact_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic req_ready,
    input  op_e  op_q,
    input  logic irq_pending,
    input  logic clk_stop_ack,
    input  logic bus_ready,
    input  logic rsp_ready,
    output logic load_req,
    output logic load_irq,
    output logic load_rsp,
    output logic cap_rdata,
    output logic irq_take,
    output logic bus_sel,
    output logic bus_enable,
    output logic clk_stop_req,
    output logic rsp_valid,
    output logic dut_rst_n
);

    xact_state_e state_q, state_d;
    logic        rst_set, rst_clr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and one-cycle control strobes
    always_comb begin
        state_d   = state_q;
        load_req  = 1'b0;
        load_irq  = 1'b0;
        load_rsp  = 1'b0;
        cap_rdata = 1'b0;
        irq_take  = 1'b0;
        rst_set   = 1'b0;
        rst_clr   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (irq_pending) begin
                    state_d  = ST_IRQ_SEND;
                    load_irq = 1'b1;
                end else if (req_valid) begin
                    state_d  = ST_FREEZE_IN;
                    load_req = 1'b1;
                end
            end
            ST_FREEZE_IN: begin
                if (clk_stop_ack) begin
                    if (op_q == OP_READ || op_q == OP_WRITE) begin
                        state_d = ST_ADDR;
                    end else begin
                        state_d = ST_FREEZE_OUT;
                        rst_set = (op_q == OP_RST_ON);
                        rst_clr = (op_q == OP_RST_OFF);
                    end
                end
            end
            ST_ADDR: state_d = ST_DATA;
            ST_DATA: begin
                if (bus_ready) begin
                    state_d   = ST_FREEZE_OUT;
                    cap_rdata = (op_q == OP_READ);
                end
            end
            ST_FREEZE_OUT: begin
                if (clk_stop_ack) begin
                    state_d  = ST_REPLY;
                    load_rsp = 1'b1;
                end
            end
            ST_REPLY: begin
                if (rsp_ready) state_d = ST_IDLE;
            end
            ST_IRQ_SEND: begin
                if (rsp_ready) begin
                    state_d  = ST_IDLE;
                    irq_take = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Moore outputs
    always_comb begin
        req_ready    = (state_q == ST_IDLE) && !irq_pending;
        bus_sel      = (state_q == ST_ADDR) || (state_q == ST_DATA);
        bus_enable   = (state_q == ST_DATA);
        clk_stop_req = (state_q == ST_FREEZE_IN) || (state_q == ST_FREEZE_OUT);
        rsp_valid    = (state_q == ST_REPLY) || (state_q == ST_IRQ_SEND);
    end

    // Side-band reset to the design, held asserted after block reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dut_rst_n <= 1'b0;
        else if (rst_set) dut_rst_n <= 1'b0;
        else if (rst_clr) dut_rst_n <= 1'b1;
    end

    AST_NO_BUS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stop_req |-> !bus_sel); // R3

    AST_ADDR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_sel) |=> (bus_sel && bus_enable)); // R4

    AST_FREEZE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_stop_req && !clk_stop_ack) |=> (clk_stop_req && !rsp_valid)); // R9

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R10

    AST_RST_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dut_rst_n) |-> !bus_sel); // R8

endmodule

// File: rtl/msg_bus_xactor.sv
module msg_bus_xactor
    import xact_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int IRQ_CNT_W = 4,
    localparam int REQ_W    = 2 + ADDR_W + DATA_W,
    localparam int RSP_W    = 2 + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [REQ_W-1:0]  req_msg,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [RSP_W-1:0]  rsp_msg,
    output logic              clk_stop_req,
    input  logic              clk_stop_ack,
    output logic              bus_sel,
    output logic              bus_enable,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready,
    output logic              dut_rst_n,
    input  logic              dut_irq
);

    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic load_req, load_irq, load_rsp, cap_rdata, irq_take, irq_pending;

    xact_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .load(load_req), .req_msg(req_msg),
        .op_q(op_q), .addr_q(addr_q), .wdata_q(wdata_q)
    );

    xact_ctrl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .op_q(op_q), .irq_pending(irq_pending), .clk_stop_ack(clk_stop_ack),
        .bus_ready(bus_ready), .rsp_ready(rsp_ready), .load_req(load_req),
        .load_irq(load_irq), .load_rsp(load_rsp), .cap_rdata(cap_rdata),
        .irq_take(irq_take), .bus_sel(bus_sel), .bus_enable(bus_enable),
        .clk_stop_req(clk_stop_req), .rsp_valid(rsp_valid), .dut_rst_n(dut_rst_n)
    );

    xact_irq_tracker #(.CNT_W(IRQ_CNT_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .irq_in(dut_irq), .take(irq_take),
        .pending(irq_pending)
    );

    xact_rsp_builder #(.DATA_W(DATA_W)) u_rsp (
        .clk(clk), .rst_n(rst_n), .cap_rdata(cap_rdata), .bus_rdata(bus_rdata),
        .load_rsp(load_rsp), .is_read(op_q == OP_READ), .load_irq(load_irq),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_msg(rsp_msg)
    );

    assign bus_addr  = addr_q;
    assign bus_wdata = wdata_q;
    assign bus_write = bus_sel && (op_q == OP_WRITE);

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_enable && !bus_ready) |=> (bus_enable && $stable(bus_addr) && $stable(bus_write))); // R5

    AST_TAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (clk_stop_req && !bus_sel)); // R2

endmodule

// File: tb/msg_bus_xactor_tb.sv
`timescale 1ns/1ps
module msg_bus_xactor_tb_top;

    localparam int AW = 8;
    localparam int DW = 8;
    localparam int CW = 2;
    localparam int REQW = 2 + AW + DW;
    localparam int RSPW = 2 + DW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [REQW-1:0] req_msg = '0;
    logic            rsp_valid;
    logic            rsp_ready = 1'b0;
    logic [RSPW-1:0] rsp_msg;
    logic            clk_stop_req, clk_stop_ack;
    logic            bus_sel, bus_enable, bus_write, bus_ready;
    logic [AW-1:0]   bus_addr;
    logic [DW-1:0]   bus_wdata, bus_rdata;
    logic            dut_rst_n;
    logic            dut_irq = 1'b0;

    msg_bus_xactor #(.ADDR_W(AW), .DATA_W(DW), .IRQ_CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_msg(req_msg), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_msg(rsp_msg), .clk_stop_req(clk_stop_req), .clk_stop_ack(clk_stop_ack),
        .bus_sel(bus_sel), .bus_enable(bus_enable), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .dut_rst_n(dut_rst_n), .dut_irq(dut_irq)
    );

    // Clock infrastructure model: acknowledge after ack_dly cycles of request
    int         ack_dly = 0;
    logic [7:0] ack_cnt = '0;
    always @(posedge clk) ack_cnt <= clk_stop_req ? ack_cnt + 8'd1 : 8'd0;
    assign clk_stop_ack = clk_stop_req && (int'(ack_cnt) >= ack_dly);

    // Bus target model: 16 words, wait_cfg wait cycles per data phase
    int            wait_cfg = 0;
    logic [7:0]    wcnt = '0;
    logic [DW-1:0] mem [16];
    initial for (int i = 0; i < 16; i++) mem[i] = '0;
    assign bus_ready = bus_enable && (int'(wcnt) >= wait_cfg);
    assign bus_rdata = mem[bus_addr[3:0]];
    always @(posedge clk) begin
        wcnt <= (bus_enable && !bus_ready) ? wcnt + 8'd1 : 8'd0;
        if (bus_enable && bus_ready && bus_write) mem[bus_addr[3:0]] <= bus_wdata;
    end

    // Monitor, sampled away from the active edge
    int            stop_cycles = 0, addr_ph = 0, data_ph = 0;
    logic [AW-1:0] mon_addr;
    logic [DW-1:0] mon_wd;
    logic          mon_wr;
    always @(negedge clk) begin
        if (clk_stop_req) stop_cycles++;
        if (bus_sel && !bus_enable) begin
            addr_ph++;
            mon_addr = bus_addr; mon_wr = bus_write; mon_wd = bus_wdata;
        end
        if (bus_sel && bus_enable) data_ph++;
    end

    int checks = 0, errors = 0;
    logic [DW-1:0] exp_mem [16];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send_req(input logic [REQW-1:0] m);
        @(negedge clk);
        req_valid = 1'b1; req_msg = m;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic get_rsp(output logic [RSPW-1:0] m);
        @(negedge clk);
        rsp_ready = 1'b1;
        while (!rsp_valid) @(negedge clk);
        m = rsp_msg;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    int last_stop, last_ap, last_dp;
    task automatic run_txn(input logic [1:0] op, input logic [AW-1:0] a,
                           input logic [DW-1:0] wd, output logic [RSPW-1:0] r);
        int s0, a0, d0;
        s0 = stop_cycles; a0 = addr_ph; d0 = data_ph;
        send_req({op, a, wd});
        get_rsp(r);
        last_stop = stop_cycles - s0; last_ap = addr_ph - a0; last_dp = data_ph - d0;
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int w, input int d);
        return DW'(a * 7 + w * 29 + d * 53 + 11);
    endfunction

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [RSPW-1:0] r, held;
        for (int i = 0; i < 16; i++) exp_mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state (checked while rst_n is held low)
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 handshake", {req_ready, rsp_valid}, 2'b10);
        chk(!bus_sel && !bus_enable && !clk_stop_req, "R1 bus idle", {bus_sel, bus_enable, clk_stop_req}, 0);
        chk(dut_rst_n == 1'b0, "R1 dut reset held", dut_rst_n, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset commands, with ack delay 1
        ack_dly = 1;
        run_txn(2'd3, 8'h00, 8'h00, r);
        chk(dut_rst_n == 1'b1, "R8 release", dut_rst_n, 1);
        chk(r == {2'd0, 8'h00}, "R8 ack msg", r, 0);
        chk(last_ap == 0 && last_dp == 0, "R8 no bus", last_ap + last_dp, 0);
        chk(last_stop == 3, "R9 reset stop len", last_stop, 3);
        run_txn(2'd2, 8'h00, 8'h00, r);
        chk(dut_rst_n == 1'b0, "R8 assert", dut_rst_n, 0);
        run_txn(2'd3, 8'h00, 8'h00, r);
        chk(dut_rst_n == 1'b1, "R8 release again", dut_rst_n, 1);

        // Sweep: every word under every wait/ack combination (R2 R4 R5 R6 R7 R9)
        for (int w = 0; w < 4; w++) begin
            for (int d = 0; d < 3; d++) begin
                wait_cfg = w; ack_dly = d;
                for (int a = 0; a < 16; a++) begin
                    run_txn(2'd1, AW'(8'hA0 + a), pat(a, w, d), r);
                    exp_mem[a] = pat(a, w, d);
                    chk(r == {2'd0, 8'h00}, "R7 write ack", r, 0);
                    chk(mon_addr == AW'(8'hA0 + a) && mon_wr && mon_wd == pat(a, w, d),
                        "R4 write addr phase", {mon_addr, mon_wr, mon_wd}, {AW'(8'hA0 + a), 1'b1, pat(a, w, d)});
                    chk(last_ap == 1 && last_dp == w + 1, "R5 write phases", last_dp, w + 1);
                    chk(last_stop == 2 * (d + 1), "R3 R9 write stop len", last_stop, 2 * (d + 1));
                end
                for (int a = 0; a < 16; a++) begin
                    run_txn(2'd0, AW'(8'hA0 + a), 8'h5A, r);
                    chk(r == {2'd1, exp_mem[a]}, "R6 read reply", r, {2'd1, exp_mem[a]});
                    chk(mon_addr == AW'(8'hA0 + a) && !mon_wr, "R4 read addr phase", {mon_addr, mon_wr}, {AW'(8'hA0 + a), 1'b0});
                    chk(last_ap == 1 && last_dp == w + 1, "R5 read phases", last_dp, w + 1);
                    chk(last_stop == 2 * (d + 1), "R9 read stop len", last_stop, 2 * (d + 1));
                end
            end
        end

        // R11 single interrupt while idle
        wait_cfg = 0; ack_dly = 0;
        @(negedge clk); dut_irq = 1'b1;
        @(negedge clk); dut_irq = 1'b0;
        get_rsp(r);
        chk(r == {2'd2, 8'h00}, "R11 irq msg", r, {2'd2, 8'h00});
        repeat (3) @(negedge clk);
        chk(!rsp_valid, "R11 one msg per edge", rsp_valid, 0);

        // R11 saturation: five edges during a long read give three messages
        wait_cfg = 20;
        send_req({2'd0, 8'hA3, 8'h00});
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); dut_irq = 1'b1;
            @(negedge clk); dut_irq = 1'b0;
        end
        get_rsp(r);
        chk(r == {2'd1, exp_mem[3]}, "R6 read during irq", r, {2'd1, exp_mem[3]});
        for (int k = 0; k < 3; k++) begin
            get_rsp(r);
            chk(r == {2'd2, 8'h00}, "R11 saturated irq msg", r, {2'd2, 8'h00});
        end
        repeat (5) @(negedge clk);
        chk(!rsp_valid && req_ready, "R11 saturation limit", {rsp_valid, req_ready}, 2'b01);

        // R10 reply hold and R12 irq before waiting request
        wait_cfg = 0;
        send_req({2'd0, 8'hA5, 8'h00});
        while (!rsp_valid) @(negedge clk);
        held = rsp_msg;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(rsp_msg == held && rsp_valid && !req_ready, "R10 reply held", rsp_msg, held);
            if (k == 0) dut_irq = 1'b1;
            if (k == 1) begin
                dut_irq = 1'b0;
                req_valid = 1'b1; req_msg = {2'd1, 8'hA6, 8'h3C};
            end
        end
        last_ap = addr_ph;
        get_rsp(r);
        chk(r == {2'd1, exp_mem[5]}, "R10 held reply value", r, {2'd1, exp_mem[5]});
        get_rsp(r);
        chk(r == {2'd2, 8'h00}, "R12 irq first", r, {2'd2, 8'h00});
        chk(addr_ph == last_ap, "R12 request still waiting", addr_ph, last_ap);
        while (!req_ready) @(negedge clk);
        @(negedge clk); req_valid = 1'b0;
        get_rsp(r);
        chk(r == {2'd0, 8'h00}, "R12 write after irq", r, 0);
        chk(mem[6] == 8'h3C, "R7 write landed", mem[6], 8'h3C);

        finish_run();
    end

endmodule